// File: doc/BRIEF.md
# Drive Identification Sequencer

This block is the host side of a parallel disk-drive register bus. After a one-cycle start request it selects one of the two devices on the cable, issues the identify command, and waits out the settle interval that the device needs before its status may be trusted. It then polls the status register until the device is ready to deliver data, and reads the whole 256-word identification block from the data port.

While the block streams past, the sequencer picks out the twenty-character serial number and emits it as bytes, one per `ser_valid` cycle, in reading order. When the last word has been read it raises a one-cycle `done`. An error report from the device, or a device that never becomes ready within a programmable number of status polls, ends the sequence with a one-cycle `err` instead.

Every bus access is a strobe of fixed length followed by an idle gap. A small transfer engine produces these accesses, and a two-phase byte emitter turns each serial word into two output bytes.

Top module: `ata_ident_seq`

## Requirements
- R1: After reset `bus_rd`, `bus_wr`, `ser_valid`, `done` and `err` are all low.
- R2: A sequence begins with exactly one write to address 6 with data 0xA0 when `dev_sel`=0 or 0xB0 when `dev_sel`=1, followed by exactly one write to address 7 with data 0xEC; no other writes occur.
- R3: The first status read (a `bus_rd` strobe at address 7) starts at least SETTLE_NS nanoseconds after the command write strobe ends.
- R4: Every `bus_rd` or `bus_wr` strobe lasts exactly STROBE_CLKS cycles with `bus_addr` held constant, the two are never high together, and at least GAP_CLKS idle cycles separate successive strobes.
- R5: Status bit 7 (busy) set, or busy clear with bit 3 (data request) and bit 0 (error) both clear, causes another status read. Data reads at address 0 begin only after a status read returned busy clear and data request set.
- R6: A successful sequence reads address 0 exactly 256 times.
- R7: Words 10 to 19 of the block, and no others, produce output bytes: bits [15:8] of a word are emitted first, then bits [7:0], one `ser_valid` cycle per byte, 20 bytes in all.
- R8: A status read with bit 7 clear and bit 0 set ends the sequence with `err`, with no data reads and no `done`.
- R9: When `timeout_lim` status reads (at least 1) have all failed to show either data ready or an error, the sequence ends with `err` and no further reads.
- R10: `done` and `err` are single-cycle pulses that never occur together. `done` rises the cycle after the last data strobe's gap ends.
- R11: `start` is ignored while a sequence is in progress: it causes no extra writes and no second completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| dev_sel | input | 1 | Device to select: 0 or 1 |
| timeout_lim | input | TO_W | Number of unproductive status polls before giving up |
| bus_addr | output | 3 | Register address on the drive bus |
| bus_wdata | output | 16 | Write data (zero outside write strobes) |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rdata | input | 16 | Read data from the device |
| ser_byte | output | 8 | Serial number character |
| ser_valid | output | 1 | `ser_byte` is valid this cycle |
| done | output | 1 | Sequence completed successfully (pulse) |
| err | output | 1 | Sequence aborted (pulse) |

## Verification
A corrupted sequencer state shows up on the bus within one access. Examples are a wrong register address, a write out of order, a status read before the settle time, or a data read before the device reported ready. The bus monitor reports each of these at the strobe where it happens. A word index that is off by one moves the serial window, so the twenty emitted bytes no longer match the expected characters or their order, and a count other than 256 reads appears by the end of the block. A faulty strobe or gap counter is caught on the first access after reset, because every strobe's length and every gap is measured.

// File: rtl/ata_ident_pkg.sv
package ata_ident_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DEV,
        SQ_CMD,
        SQ_SETTLE,
        SQ_POLL,
        SQ_DATA
    } seq_st_e;

    typedef enum logic [1:0] {
        XF_IDLE,
        XF_STB,
        XF_GAP
    } xf_st_e;

    typedef enum logic [1:0] {
        EM_IDLE,
        EM_HI,
        EM_LO
    } em_st_e;

    localparam logic [2:0] REG_DATA    = 3'd0;
    localparam logic [2:0] REG_DEVHEAD = 3'd6;
    localparam logic [2:0] REG_CMDSTAT = 3'd7;

    localparam logic [7:0] CMD_IDENT    = 8'hEC;
    localparam logic [7:0] DEVHEAD_BASE = 8'hA0;

    localparam int ST_BSY = 7;
    localparam int ST_DRQ = 3;
    localparam int ST_ERR = 0;

endpackage

// File: rtl/ata_bus_xfer.sv
module ata_bus_xfer
    import ata_ident_pkg::*;
#(
    parameter int STROBE_CLKS = 3,
    parameter int GAP_CLKS    = 2,
    parameter int AW          = 3,
    parameter int DW          = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ack,
    output logic [DW-1:0] rd_word,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_rd,
    output logic          bus_wr,
    input  logic [DW-1:0] bus_rdata
);

    localparam int CNT_MAX = (STROBE_CLKS > GAP_CLKS) ? STROBE_CLKS : GAP_CLKS;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] STB_LOAD = CW'(STROBE_CLKS - 1);
    localparam logic [CW-1:0] GAP_LOAD = CW'(GAP_CLKS - 1);

    typedef struct packed {
        xf_st_e        st;
        logic [CW-1:0] cnt;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } xf_t;

    xf_t xf_d, xf_q;

    always_comb begin
        xf_d = xf_q;
        case (xf_q.st)
            XF_IDLE: begin
                if (req) begin
                    xf_d.st    = XF_STB;
                    xf_d.cnt   = STB_LOAD;
                    xf_d.wr    = req_wr;
                    xf_d.addr  = req_addr;
                    xf_d.wdata = req_wdata;
                end
            end
            XF_STB: begin
                if (xf_q.cnt == '0) begin
                    if (!xf_q.wr) begin
                        xf_d.rdata = bus_rdata;
                    end
                    xf_d.st  = XF_GAP;
                    xf_d.cnt = GAP_LOAD;
                end else begin
                    xf_d.cnt = xf_q.cnt - 1'b1;
                end
            end
            XF_GAP: begin
                if (xf_q.cnt == '0) begin
                    xf_d.st = XF_IDLE;
                end else begin
                    xf_d.cnt = xf_q.cnt - 1'b1;
                end
            end
            default: xf_d.st = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xf_q <= '{st: XF_IDLE, cnt: '0, wr: 1'b0, addr: '0, wdata: '0, rdata: '0};
        end else begin
            xf_q <= xf_d;
        end
    end

    assign bus_rd    = (xf_q.st == XF_STB) && !xf_q.wr;
    assign bus_wr    = (xf_q.st == XF_STB) && xf_q.wr;
    assign bus_addr  = xf_q.addr;
    assign bus_wdata = bus_wr ? xf_q.wdata : '0;
    assign ack       = (xf_q.st == XF_GAP) && (xf_q.cnt == '0);
    assign rd_word   = xf_q.rdata;

    // R4: read and write strobes are exclusive
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R4: address does not move while a strobe is held
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && $past(bus_rd || bus_wr)) |-> $stable(bus_addr));

    // R4: a strobe that ends is followed by an idle cycle
    p_idle_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd || bus_wr) |=> !(bus_rd || bus_wr));

endmodule

// File: rtl/ata_serial_emit.sv
module ata_serial_emit
    import ata_ident_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] word_in,
    output logic [7:0]  ser_byte,
    output logic        ser_valid
);

    typedef struct packed {
        em_st_e      st;
        logic [15:0] word;
    } em_t;

    em_t em_d, em_q;

    always_comb begin
        em_d = em_q;
        if (load) begin
            em_d.st   = EM_HI;
            em_d.word = word_in;
        end else begin
            case (em_q.st)
                EM_HI:   em_d.st = EM_LO;
                EM_LO:   em_d.st = EM_IDLE;
                default: em_d.st = EM_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            em_q <= '{st: EM_IDLE, word: '0};
        end else begin
            em_q <= em_d;
        end
    end

    assign ser_valid = (em_q.st != EM_IDLE);
    assign ser_byte  = (em_q.st == EM_HI) ? em_q.word[15:8] :
                       (em_q.st == EM_LO) ? em_q.word[7:0]  : 8'h00;

    // R7: a new word never arrives before the high byte has gone out
    p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (em_q.st != EM_HI));

endmodule

// File: rtl/ata_ident_seq.sv
module ata_ident_seq
    import ata_ident_pkg::*;
#(
    parameter int CLK_MHZ     = 200,
    parameter int SETTLE_NS   = 400,
    parameter int STROBE_CLKS = 3,
    parameter int GAP_CLKS    = 2,
    parameter int TO_W        = 16,
    parameter int WORDS       = 256,
    parameter int SER_FIRST   = 10,
    parameter int SER_WORDS   = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            dev_sel,
    input  logic [TO_W-1:0] timeout_lim,
    output logic [2:0]      bus_addr,
    output logic [15:0]     bus_wdata,
    output logic            bus_rd,
    output logic            bus_wr,
    input  logic [15:0]     bus_rdata,
    output logic [7:0]      ser_byte,
    output logic            ser_valid,
    output logic            done,
    output logic            err
);

    localparam int SETTLE_RAW  = (SETTLE_NS * CLK_MHZ + 999) / 1000;
    localparam int SETTLE_CLKS = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
    localparam int SW          = $clog2(SETTLE_CLKS + 1);
    localparam int WIW         = $clog2(WORDS);
    localparam logic [SW-1:0]  SETTLE_LOAD = SW'(SETTLE_CLKS - 1);
    localparam logic [WIW-1:0] LAST_W  = WIW'(WORDS - 1);
    localparam logic [WIW-1:0] SER_LO  = WIW'(SER_FIRST);
    localparam logic [WIW-1:0] SER_HI  = WIW'(SER_FIRST + SER_WORDS - 1);

    typedef struct packed {
        seq_st_e         st;
        logic            dev;
        logic [SW-1:0]   settle;
        logic [TO_W-1:0] polls;
        logic [WIW-1:0]  widx;
        logic            done;
        logic            err;
    } seq_t;

    seq_t q, d;

    logic            x_req, x_wr, x_ack;
    logic [2:0]      x_addr;
    logic [15:0]     x_wdata, x_rd;
    logic            em_load;
    logic [TO_W-1:0] polls_inc;
    logic            in_serial;

    assign polls_inc = q.polls + 1'b1;
    assign in_serial = (q.widx >= SER_LO) && (q.widx <= SER_HI);

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.err   = 1'b0;
        x_req   = 1'b0;
        x_wr    = 1'b0;
        x_addr  = REG_DATA;
        x_wdata = '0;
        em_load = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (start) begin
                    d.st    = SQ_DEV;
                    d.dev   = dev_sel;
                    d.polls = '0;
                    d.widx  = '0;
                end
            end
            SQ_DEV: begin
                x_req   = 1'b1;
                x_wr    = 1'b1;
                x_addr  = REG_DEVHEAD;
                x_wdata = {8'h00, DEVHEAD_BASE | {3'b000, q.dev, 4'b0000}};
                if (x_ack) begin
                    d.st = SQ_CMD;
                end
            end
            SQ_CMD: begin
                x_req   = 1'b1;
                x_wr    = 1'b1;
                x_addr  = REG_CMDSTAT;
                x_wdata = {8'h00, CMD_IDENT};
                if (x_ack) begin
                    d.st     = SQ_SETTLE;
                    d.settle = SETTLE_LOAD;
                end
            end
            SQ_SETTLE: begin
                if (q.settle == '0) begin
                    d.st = SQ_POLL;
                end else begin
                    d.settle = q.settle - 1'b1;
                end
            end
            SQ_POLL: begin
                x_req  = 1'b1;
                x_addr = REG_CMDSTAT;
                if (x_ack) begin
                    if (!x_rd[ST_BSY] && x_rd[ST_ERR]) begin
                        d.err = 1'b1;
                        d.st  = SQ_IDLE;
                    end else if (!x_rd[ST_BSY] && x_rd[ST_DRQ]) begin
                        d.st   = SQ_DATA;
                        d.widx = '0;
                    end else begin
                        d.polls = polls_inc;
                        if (polls_inc >= timeout_lim) begin
                            d.err = 1'b1;
                            d.st  = SQ_IDLE;
                        end
                    end
                end
            end
            SQ_DATA: begin
                x_req  = 1'b1;
                x_addr = REG_DATA;
                if (x_ack) begin
                    em_load = in_serial;
                    if (q.widx == LAST_W) begin
                        d.done = 1'b1;
                        d.st   = SQ_IDLE;
                    end else begin
                        d.widx = q.widx + 1'b1;
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, dev: 1'b0, settle: '0, polls: '0,
                   widx: '0, done: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    ata_bus_xfer #(
        .STROBE_CLKS (STROBE_CLKS),
        .GAP_CLKS    (GAP_CLKS),
        .AW          (3),
        .DW          (16)
    ) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (x_req),
        .req_wr    (x_wr),
        .req_addr  (x_addr),
        .req_wdata (x_wdata),
        .ack       (x_ack),
        .rd_word   (x_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata)
    );

    ata_serial_emit u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (em_load),
        .word_in   (x_rd),
        .ser_byte  (ser_byte),
        .ser_valid (ser_valid)
    );

    assign done = q.done;
    assign err  = q.err;

    // Checker state observed from the bus pins
    localparam logic [SW:0] SINCE_SAT = (SW + 1)'(SETTLE_CLKS);
    logic [SW:0] since_cmd_q;
    logic        dev_seen_q;
    logic [7:0]  last_stat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_cmd_q <= SINCE_SAT;
            dev_seen_q  <= 1'b0;
            last_stat_q <= 8'h80;
        end else begin
            if (bus_wr && bus_addr == REG_CMDSTAT) begin
                since_cmd_q <= '0;
            end else if (since_cmd_q != SINCE_SAT) begin
                since_cmd_q <= since_cmd_q + 1'b1;
            end
            if (bus_wr && bus_addr == REG_DEVHEAD) begin
                dev_seen_q <= 1'b1;
            end else if (done || err) begin
                dev_seen_q <= 1'b0;
            end
            if (bus_rd && bus_addr == REG_CMDSTAT) begin
                last_stat_q <= bus_rdata[7:0];
            end
        end
    end

    // R2: command write only after the device-head write of this sequence
    p_cmd_after_dev_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_wr) && bus_addr == REG_CMDSTAT) |-> dev_seen_q);

    // R3: no status read inside the settle window
    p_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_rd) && bus_addr == REG_CMDSTAT) |-> (since_cmd_q == SINCE_SAT));

    // R5: data reads gated on a ready status
    p_data_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_rd) && bus_addr == REG_DATA) |-> (!last_stat_q[ST_BSY] && last_stat_q[ST_DRQ]));

    // R10: completion and abort are exclusive single pulses
    p_done_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: a sequence is only entered from idle
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_DEV && $past(q.st) != SQ_DEV) |-> ($past(q.st) == SQ_IDLE));

endmodule

// File: tb/ata_ident_seq_bench.sv
module ata_ident_seq_bench;

    localparam int STROBE = 3;
    localparam int GAP    = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dev_sel = 1'b0;
    logic [15:0] timeout_lim = 16'd100;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_rd, bus_wr;
    logic [15:0] bus_rdata;
    logic [7:0]  ser_byte;
    logic        ser_valid, done, err;

    always #2.5 clk = ~clk;

    ata_ident_seq u_ata_ident_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_sel(dev_sel),
        .timeout_lim(timeout_lim), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .ser_byte(ser_byte), .ser_valid(ser_valid), .done(done), .err(err)
    );

    int checks = 0;
    int errors = 0;

    // device model settings
    int         busy_n   = 0;
    logic [7:0] busy_val = 8'h80;
    logic [7:0] fin_stat = 8'h58;

    // monitor state
    int         n_wr, n_stat, n_data, n_ser, n_done, n_err;
    int         bad_len, bad_gap, bad_addr;
    logic [2:0] wr_a [4];
    logic [15:0] wr_d [4];
    logic [7:0] ser [32];
    realtime    t_cmd, t_stat;
    bit         first_stat, seen_any;
    int         run_len, gap_run;
    logic [2:0] st_addr;
    logic       p_stb = 1'b0, p_wr = 1'b0;
    logic [2:0] p_addr = '0;
    logic [15:0] p_wdata = '0;

    function automatic logic [15:0] word_of(int i);
        if (i >= 10 && i <= 19)
            return {8'(8'h41 + 2 * (i - 10)), 8'(8'h42 + 2 * (i - 10))};
        return 16'h5A00 ^ 16'(i);
    endfunction

    always_comb begin
        if (bus_addr == 3'd7)
            bus_rdata = {8'h00, (n_stat < busy_n) ? busy_val : fin_stat};
        else
            bus_rdata = word_of(n_data);
    end

    task automatic clear_mon();
        n_wr = 0; n_stat = 0; n_data = 0; n_ser = 0; n_done = 0; n_err = 0;
        bad_len = 0; bad_gap = 0; bad_addr = 0;
        first_stat = 0; seen_any = 0; run_len = 0; gap_run = 0;
        t_cmd = 0; t_stat = 0;
    endtask

    always @(negedge clk) begin
        logic stb;
        stb = bus_rd | bus_wr;
        if (stb) begin
            if (!p_stb) begin
                run_len = 1;
                if (seen_any && gap_run < GAP) bad_gap++;
                st_addr = bus_addr;
                if (bus_rd && bus_addr == 3'd7 && !first_stat) begin
                    first_stat = 1;
                    t_stat = $realtime;
                end
            end else begin
                run_len++;
                if (bus_addr != st_addr) bad_addr++;
            end
        end else begin
            if (p_stb) begin
                if (run_len != STROBE) bad_len++;
                gap_run = 1;
                seen_any = 1;
                if (p_wr) begin
                    if (n_wr < 4) begin
                        wr_a[n_wr] = p_addr;
                        wr_d[n_wr] = p_wdata;
                    end
                    n_wr++;
                    if (p_addr == 3'd7) t_cmd = $realtime;
                end else if (p_addr == 3'd7) begin
                    n_stat++;
                end else if (p_addr == 3'd0) begin
                    n_data++;
                end
            end else begin
                gap_run++;
            end
        end
        if (ser_valid) begin
            if (n_ser < 32) ser[n_ser] = ser_byte;
            n_ser++;
        end
        if (done) n_done++;
        if (err) n_err++;
        p_stb = stb;
        p_wr = bus_wr;
        p_addr = bus_addr;
        p_wdata = bus_wdata;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Run one sequence; poke_at > 0 pulses start again mid-run
    task automatic run_ident(input logic dev, input int busy, input logic [7:0] bval,
                             input logic [7:0] fin, input int lim, input int poke_at);
        int cyc;
        @(posedge clk);
        #1;
        busy_n = busy; busy_val = bval; fin_stat = fin;
        clear_mon();
        @(negedge clk); #1;
        dev_sel = dev; timeout_lim = 16'(lim); start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        cyc = 0;
        while (n_done == 0 && n_err == 0 && cyc < 20000) begin
            @(negedge clk); #1;
            cyc++;
            if (poke_at > 0 && cyc == poke_at) begin
                start = 1'b1; dev_sel = ~dev;
            end
            if (poke_at > 0 && cyc == poke_at + 1) start = 1'b0;
        end
        chk("run finished", (cyc < 20000) ? 1 : 0, 1);
        repeat (20) @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 bus_rd", int'(bus_rd), 0);
        chk("R1 bus_wr", int'(bus_wr), 0);
        chk("R1 ser_valid", int'(ser_valid), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);
    endtask

    task automatic check_success(input logic [7:0] devhead, input int exp_stat);
        chk("R2 write count", n_wr, 2);
        chk("R2 devhead addr", int'(wr_a[0]), 6);
        chk("R2 devhead data", int'(wr_d[0]), int'(devhead));
        chk("R2 command addr", int'(wr_a[1]), 7);
        chk("R2 command data", int'(wr_d[1]), 'hEC);
        chk("R3 settle", (t_stat - t_cmd >= 400.0) ? 1 : 0, 1);
        chk("R4 strobe length", bad_len, 0);
        chk("R4 gap", bad_gap, 0);
        chk("R4 addr hold", bad_addr, 0);
        chk("R5 status reads", n_stat, exp_stat);
        chk("R6 data reads", n_data, 256);
        chk("R7 byte count", n_ser, 20);
        for (int j = 0; j < 20; j++)
            chk("R7 serial byte", int'(ser[j]), 'h41 + j);
        chk("R10 done pulses", n_done, 1);
        chk("R10 err pulses", n_err, 0);
    endtask

    // busy three polls, device 0
    task automatic t_normal();
        run_ident(1'b0, 3, 8'h80, 8'h58, 100, 0);
        check_success(8'hA0, 4);
    endtask

    // not-busy-but-not-ready twice, device 1
    task automatic t_dev1_notready();
        run_ident(1'b1, 2, 8'h50, 8'h58, 100, 0);
        check_success(8'hB0, 3);
    endtask

    task automatic t_error();
        run_ident(1'b0, 2, 8'h80, 8'h51, 100, 0);
        chk("R8 err pulses", n_err, 1);
        chk("R8 done pulses", n_done, 0);
        chk("R8 status reads", n_stat, 3);
        chk("R8 data reads", n_data, 0);
        chk("R8 ser bytes", n_ser, 0);
    endtask

    task automatic t_timeout();
        run_ident(1'b0, 0, 8'h80, 8'h50, 5, 0);
        chk("R9 err pulses", n_err, 1);
        chk("R9 done pulses", n_done, 0);
        chk("R9 status reads", n_stat, 5);
        chk("R9 data reads", n_data, 0);
    endtask

    task automatic t_start_ignored();
        run_ident(1'b0, 1, 8'h80, 8'h58, 100, 300);
        chk("R11 write count", n_wr, 2);
        chk("R11 devhead data", int'(wr_d[0]), 'hA0);
        chk("R11 done pulses", n_done, 1);
        chk("R11 data reads", n_data, 256);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        clear_mon();
        repeat (5) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_normal();
        t_dev1_notready();
        t_error();
        t_timeout();
        t_start_ignored();
        t_normal();
        summary();
        $finish;
    end

endmodule